// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Replacement Selector

This block holds the replacement state of an 8-way set-associative cache and names the way to fill next. Each set keeps a 7-bit binary decision tree and an 8-bit mask of valid ways. The victim is chosen combinationally from the addressed set. If any way is still empty, the victim is the lowest-numbered empty way. If the set is full, the victim is found by walking the tree.

The cache controller presents a set index. It reads `victim` and `all_full` in the same cycle. When a way is touched, whether on a hit or on a fill, the controller pulses `acc_en` together with that way. On that clock edge the tree of the set is steered away from the touched way and the way is marked valid. `inv_en` empties the whole addressed set. Tags and data storage are kept elsewhere.

Top module: `tree_plru8`

## Requirements
- R1: After reset every set has an empty valid mask and tree bits all zero, so `victim` reads 0 and `all_full` reads 0 for every set index.
- R2: While the addressed set has at least one empty way, `victim` is the lowest-numbered way whose valid bit is clear, and `all_full` is 0.
- R3: While all 8 ways of the addressed set are valid, `all_full` is 1 and `victim` comes from tree bits t[6:0] as follows. If t0=1: when t2=1 the victim is 6 or 7, picked by t6 (1 gives 7); when t2=0 it is 4 or 5, picked by t5 (1 gives 5). If t0=0: when t1=1 the victim is 2 or 3, picked by t4 (1 gives 3); when t1=0 it is 0 or 1, picked by t3 (1 gives 1).
- R4: An access to way w rewrites the set's tree as t = (t & ~M[w]) | V[w], where M = 11,11,19,19,37,37,69,69 and V = 11,3,17,1,36,4,64,0 for w = 0..7. These values are decimal, and bit k of each value is tk.
- R5: An access to way w sets valid bit w of the addressed set on the clock edge where `acc_en` is 1.
- R6: The tree update is applied on every access, whether the way was already valid (a hit) or not (a fill).
- R7: An access or invalidate changes only the addressed set. Every other set keeps its state.
- R8: When the set is full, the way accessed on one edge is never the victim of that set on the following cycle.
- R9: `inv_en` clears the valid mask of the addressed set and leaves its tree bits unchanged. If `acc_en` is also 1 on the same edge, only the accessed way stays valid.
- R10: With `acc_en` and `inv_en` both 0, no state changes, whatever the set index or way inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_idx | input | 7 | Addressed set |
| acc_en | input | 1 | Access strobe; updates the tree and the valid bit on the edge |
| acc_way | input | 3 | Way touched by the access |
| inv_en | input | 1 | Invalidate all ways of the addressed set |
| victim | output | 3 | Way to fill in the addressed set (combinational) |
| all_full | output | 1 | All 8 ways of the addressed set are valid (combinational) |

## Verification
`victim` and `all_full` are combinational, so they are due in the same cycle as `set_idx`. The bench sets `set_idx` at the falling edge and samples one nanosecond later, well before the next rising edge. An access or invalidate takes effect on the rising edge where its strobe is high. The bench's reference model therefore applies an update only after it has checked the pre-edge victim, and the effect is first compared in the next cycle. The R8 check follows the same timing: it reads the victim in the cycle after the access edge.

// File: rtl/tree_plru8.sv
module tree_plru8 #(
  parameter int SETS = 128,
  localparam int SW = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_idx,
  input  logic          acc_en,
  input  logic [2:0]    acc_way,
  input  logic          inv_en,
  output logic [2:0]    victim,
  output logic          all_full
);

  logic [6:0] tree_q  [SETS];
  logic [7:0] valid_q [SETS];

  logic [6:0] cur_tree;
  logic [7:0] cur_valid;
  assign cur_tree  = tree_q[set_idx];
  assign cur_valid = valid_q[set_idx];
  assign all_full  = &cur_valid;

  logic [2:0] first_free;
  always_comb begin
    first_free = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (!cur_valid[i]) first_free = 3'(i);
  end

  logic       hi, mid;
  logic [2:0] leaf_idx;
  assign hi       = cur_tree[0];
  assign mid      = hi ? cur_tree[2] : cur_tree[1];
  assign leaf_idx = 3'd3 + {1'b0, hi, mid};

  logic [2:0] tree_way;
  assign tree_way = {hi, mid, cur_tree[leaf_idx]};
  assign victim   = all_full ? tree_way : first_free;

  logic [6:0] next_tree;
  logic [2:0] mid_pos, leaf_pos;
  assign mid_pos  = acc_way[2] ? 3'd2 : 3'd1;
  assign leaf_pos = 3'd3 + {1'b0, acc_way[2:1]};
  always_comb begin
    next_tree           = cur_tree;
    next_tree[0]        = ~acc_way[2];
    next_tree[mid_pos]  = ~acc_way[1];
    next_tree[leaf_pos] = ~acc_way[0];
  end

  logic [7:0] next_valid;
  assign next_valid = (inv_en ? 8'd0 : cur_valid) |
                      (acc_en ? (8'd1 << acc_way) : 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tree_q[s]  <= '0;
        valid_q[s] <= '0;
      end
    end else begin
      if (acc_en) tree_q[set_idx] <= next_tree;
      if (acc_en || inv_en) valid_q[set_idx] <= next_valid;
    end
  end

endmodule

// File: rtl/tree_plru8_chk.sv
module tree_plru8_chk #(
  parameter int SW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] set_idx,
  input logic          acc_en,
  input logic [2:0]    acc_way,
  input logic          inv_en,
  input logic [2:0]    victim,
  input logic          all_full,
  input logic [6:0]    cur_tree,
  input logic [7:0]    cur_valid
);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (cur_valid == 8'd0 && cur_tree == 7'd0 && victim == 3'd0));

  a_r2_victim_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !all_full |-> !cur_valid[victim]);

  a_r5_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_en) && set_idx == $past(set_idx)) |-> cur_valid[$past(acc_way)]);

  a_r8_not_recent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_en) && set_idx == $past(set_idx) && all_full) |-> victim != $past(acc_way));

  a_r9_inv_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_en) && !$past(acc_en) && set_idx == $past(set_idx)) |-> (cur_valid == 8'd0 && victim == 3'd0));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(acc_en) && !$past(inv_en) && set_idx == $past(set_idx)) |-> ($stable(cur_tree) && $stable(cur_valid)));

endmodule

bind tree_plru8 tree_plru8_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_en(acc_en),
  .acc_way(acc_way), .inv_en(inv_en), .victim(victim), .all_full(all_full),
  .cur_tree(cur_tree), .cur_valid(cur_valid)
);

// File: tb/test_tree_plru8.sv
module test_tree_plru8;
  logic clk = 0, rst_n = 0;
  logic [6:0] set_idx = 0;
  logic acc_en = 0, inv_en = 0;
  logic [2:0] acc_way = 0;
  logic [2:0] victim;
  logic all_full;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  tree_plru8 i_tree_plru8 (.*);

  localparam logic [6:0] MSK [8] = '{7'd11, 7'd11, 7'd19, 7'd19, 7'd37, 7'd37, 7'd69, 7'd69};
  localparam logic [6:0] VAL [8] = '{7'd11, 7'd3, 7'd17, 7'd1, 7'd36, 7'd4, 7'd64, 7'd0};
  // {way accessed, expected victim before the access} on set 5
  localparam logic [5:0] VEC [13] = '{
    {3'd0,3'd0}, {3'd1,3'd1}, {3'd2,3'd2}, {3'd3,3'd3}, {3'd4,3'd4}, {3'd5,3'd5},
    {3'd6,3'd6}, {3'd7,3'd7}, {3'd0,3'd0}, {3'd4,3'd4}, {3'd2,3'd2}, {3'd6,3'd6},
    {3'd1,3'd1}};

  logic [6:0] mt [128];
  logic [7:0] mv [128];

  function automatic logic [2:0] ref_victim(input logic [6:0] s);
    logic [6:0] t = mt[s];
    if (mv[s] != 8'hff) begin
      for (int i = 0; i < 8; i++) if (!mv[s][i]) return 3'(i);
    end
    if (t[0]) return t[2] ? (t[6] ? 3'd7 : 3'd6) : (t[5] ? 3'd5 : 3'd4);
    return t[1] ? (t[4] ? 3'd3 : 3'd2) : (t[3] ? 3'd1 : 3'd0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 128; s++) begin mt[s] = 0; mv[s] = 0; end
  endtask

  task automatic cycle(input logic [6:0] s, input logic a, input logic [2:0] w, input logic inv,
                       input string req);
    @(negedge clk);
    set_idx = s; acc_en = a; acc_way = w; inv_en = inv;
    #1;
    check(req, victim, ref_victim(s));
    check(req, all_full, mv[s] == 8'hff);
    @(posedge clk);
    if (inv) mv[s] = 0;
    if (a) begin
      mt[s] = (mt[s] & ~MSK[w]) | VAL[w];
      mv[s] = mv[s] | (8'd1 << w);
    end
  endtask

  initial begin
    #150000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    #20 rst_n = 1;
    // R1 reset state
    for (int s = 0; s < 128; s += 37) cycle(7'(s), 0, 0, 0, "R1");

    // Vector table: R2 fills, then R3/R4/R6 hits on a full set
    foreach (VEC[i]) begin
      @(negedge clk);
      set_idx = 5; acc_en = 1; acc_way = VEC[i][5:3]; inv_en = 0;
      #1;
      check(i < 8 ? "R2" : "R3", victim, VEC[i][2:0]);
      check("R4", victim, ref_victim(5));
      @(posedge clk);
      mt[5] = (mt[5] & ~MSK[VEC[i][5:3]]) | VAL[VEC[i][5:3]];
      mv[5] = mv[5] | (8'd1 << VEC[i][5:3]);
    end
    cycle(5, 0, 0, 0, "R6");

    // R7: another set leaves set 5 alone
    cycle(9, 1, 3, 0, "R7");
    cycle(9, 0, 0, 1, "R7");
    cycle(5, 0, 0, 0, "R7");

    // R10: idle with moving way/set inputs
    for (int k = 0; k < 8; k++) cycle(7'(k), 0, 3'(k), 0, "R10");
    cycle(5, 0, 0, 0, "R10");

    // R9: invalidate keeps tree, combined with access keeps one way
    cycle(5, 0, 0, 1, "R9");
    cycle(5, 0, 0, 0, "R9");
    for (int w = 0; w < 8; w++) cycle(5, 1, 3'(w), 0, "R9");
    cycle(5, 1, 6, 1, "R9");
    cycle(5, 0, 0, 0, "R9");

    // Random accesses on few sets; R8 after each full-set access
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] s = 7'($urandom_range(0, 3));
      logic [2:0] w = 3'($urandom_range(0, 7));
      logic inv = ($urandom_range(0, 63) == 0);
      cycle(s, 1, w, inv, "R4");
      if (mv[s] == 8'hff) begin
        @(negedge clk);
        set_idx = s; acc_en = 0; inv_en = 0;
        #1;
        checks++;
        if (victim == w) begin
          errors++;
          $display("FAIL R8: actual=%0d expected=not %0d", victim, w);
        end
        check("R3", victim, ref_victim(s));
      end
    end

    // R1 again: reset mid-run clears everything
    @(negedge clk); acc_en = 0; inv_en = 0; rst_n = 0;
    model_clear();
    #20; @(negedge clk); rst_n = 1;
    for (int s = 0; s < 4; s++) cycle(7'(s), 0, 0, 0, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule